// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central scheduler for a floating-point pipeline that issues in order and completes out of order. Each cycle it may accept one decoded instruction through a valid/ready handshake: a target unit code, an opcode, a destination register and two source registers. It tracks every instruction through four steps: issue, operand read, execution and result write. It decides in which cycle each step may happen. Operands are never forwarded, so a value is always read from the register file.

The block holds two tables. The first has one entry per functional unit. Each entry records the stage, the opcode, the destination and both sources, the unit that will produce each source, and a ready flag for each source. The second table records, for each architectural register, which unit owes it a result. Four non-pipelined units (integer/load, multiplier, adder, divider) are modelled inside the block as latency counters. The block drives per-unit operand-read strobes with the source addresses, an execution-finished pulse per unit, and one register-file write port. The write port reports the register and the unit that owns the write.

Top module: `sb_ctrl`

## Requirements
- R1: After synchronous reset every unit is idle (`fu_busy` = 0), `rd_en` and `wr_en` are low, and `in_ready` is high for any request with a legal unit code and any destination.
- R2: Unit codes are 1 = integer/load, 2 = multiply, 3 = add, 4 = divide. `rd_en`, `ex_done` and `fu_busy` bit i belong to unit code i+1. A request aimed at a busy unit is held (`in_ready` low) until the cycle after that unit writes its result.
- R3: A request whose destination still has a pending write from any unit is held until the cycle after that write.
- R4: A request with unit code 0, 5, 6 or 7 is never accepted, and it leaves every unit idle.
- R5: A unit whose sources have no pending producer reads its operands in the cycle right after issue.
- R6: A source that waits on a producer is read in the cycle after the producer's write, never in the write cycle itself. This also holds when both sources wait on the same producer, and when the instruction issues in the same cycle as that write.
- R7: A unit executes for its latency parameter after the read (defaults: integer 1, add 2, multiply 10, divide 40). With no hazard, the result write comes L+2 cycles after issue. Independent instructions may therefore complete out of order.
- R8: A finished unit does not write while another unit still holds a ready, unread source equal to its destination. It writes in the cycle after that reader has taken its operands.
- R9: When several units are allowed to write in the same cycle, the lowest unit code gets the port. The others retry in the next cycle.
- R10: During a write, `wr_addr` is the destination of the instruction and `wr_fu` is its unit code. The write frees the unit and the destination's pending entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction accepted this cycle when valid |
| in_fu | input | 3 | Target unit code (1..4) |
| in_op | input | OP_W | Opcode recorded in the unit |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| rd_en | output | NUM_FU | Per-unit operand read strobe; execution starts after it |
| rd_addr1 | output | NUM_FU*REG_W | Per-unit first source address |
| rd_addr2 | output | NUM_FU*REG_W | Per-unit second source address |
| start_op | output | NUM_FU*OP_W | Per-unit recorded opcode |
| ex_done | output | NUM_FU | Per-unit last execution cycle |
| wr_en | output | 1 | Register-file write strobe |
| wr_addr | output | REG_W | Register written |
| wr_fu | output | 3 | Unit code that owns the write |
| fu_busy | output | NUM_FU | Per-unit occupied flag |

## Verification
The assertions assume that `in_valid` and the request fields stay stable and legal while a request waits. They also assume that the register file applies a write at the clock edge, so a read in the same cycle returns the old value. The stimulus holds each request on its fields until it is accepted, then lowers `in_valid` or presents the next request. Each scenario starts with all units idle, so every expected cycle is counted from an issue whose surroundings are known.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_FU = 4;
  localparam int TAG_W  = $clog2(NUM_FU + 1);

  typedef logic [TAG_W-1:0] fu_tag_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPND,
    ST_EXEC,
    ST_DONE
  } slot_st_e;

  // a pending reader exists when a source matches and is ready but unread
  function automatic logic war_pending(input logic j_match, input logic j_rdy,
                                       input logic k_match, input logic k_rdy);
    return (j_match && j_rdy) || (k_match && k_rdy);
  endfunction

  // isolate the least significant set bit
  function automatic logic [NUM_FU-1:0] first_set(input logic [NUM_FU-1:0] v);
    return v & (~v + NUM_FU'(1));
  endfunction
endpackage

// File: rtl/sb_regstat.sv
module sb_regstat
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] look_a,
  input  logic [REG_W-1:0] look_b,
  input  logic [REG_W-1:0] look_d,
  output fu_tag_t          tag_a,
  output fu_tag_t          tag_b,
  output fu_tag_t          tag_d,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_addr,
  input  fu_tag_t          set_tag,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_addr
);
  fu_tag_t owner [NUM_REGS];

  assign tag_a = owner[look_a];
  assign tag_b = owner[look_b];
  assign tag_d = owner[look_d];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) owner[r] <= '0;
    end else begin
      if (clr_en) owner[clr_addr] <= '0;
      if (set_en) owner[set_addr] <= set_tag;
    end
  end

  // R3
  waw_clean_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |-> owner[set_addr] == '0);
  // R10
  clr_owned_chk: assert property (@(posedge clk) disable iff (rst)
    clr_en |-> owner[clr_addr] != '0);
endmodule

// File: rtl/sb_fu_slot.sv
module sb_fu_slot
  import sb_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int OP_W  = 4,
  parameter int CNT_W = 6,
  parameter int LAT   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iss_go,
  input  logic [OP_W-1:0]  iss_op,
  input  logic [REG_W-1:0] iss_fi,
  input  logic [REG_W-1:0] iss_fj,
  input  logic [REG_W-1:0] iss_fk,
  input  fu_tag_t          iss_qj,
  input  fu_tag_t          iss_qk,
  input  logic             wb_en,
  input  fu_tag_t          wb_tag,
  input  logic             grant,
  output logic             busy,
  output logic [OP_W-1:0]  op,
  output logic [REG_W-1:0] fi,
  output logic [REG_W-1:0] fj,
  output logic [REG_W-1:0] fk,
  output logic             rj,
  output logic             rk,
  output logic             rd_go,
  output logic             done,
  output logic             want_wr
);
  slot_st_e         st;
  fu_tag_t          qj, qk;
  logic [CNT_W-1:0] cnt;
  fu_tag_t          cap_qj, cap_qk;
  logic             wake_j, wake_k;

  // a producer writing in the issue cycle counts as already written
  assign cap_qj = (wb_en && iss_qj == wb_tag) ? fu_tag_t'(0) : iss_qj;
  assign cap_qk = (wb_en && iss_qk == wb_tag) ? fu_tag_t'(0) : iss_qk;

  assign wake_j  = wb_en && (qj != '0) && (qj == wb_tag);
  assign wake_k  = wb_en && (qk != '0) && (qk == wb_tag);
  assign busy    = (st != ST_IDLE);
  assign rd_go   = (st == ST_OPND) && rj && rk;
  assign done    = (st == ST_EXEC) && (cnt == CNT_W'(1));
  assign want_wr = (st == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      op  <= '0;
      fi  <= '0;
      fj  <= '0;
      fk  <= '0;
      qj  <= '0;
      qk  <= '0;
      rj  <= 1'b0;
      rk  <= 1'b0;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (iss_go) begin
          st <= ST_OPND;
          op <= iss_op;
          fi <= iss_fi;
          fj <= iss_fj;
          fk <= iss_fk;
          qj <= cap_qj;
          qk <= cap_qk;
          rj <= (cap_qj == '0);
          rk <= (cap_qk == '0);
        end
        ST_OPND: begin
          if (rd_go) begin
            st  <= ST_EXEC;
            cnt <= CNT_W'(LAT);
            rj  <= 1'b0;
            rk  <= 1'b0;
            qj  <= '0;
            qk  <= '0;
          end else begin
            if (wake_j) rj <= 1'b1;
            if (wake_k) rk <= 1'b1;
          end
        end
        ST_EXEC: begin
          cnt <= cnt - CNT_W'(1);
          if (cnt == CNT_W'(1)) st <= ST_DONE;
        end
        ST_DONE: if (grant) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9
  grant_when_done_chk: assert property (@(posedge clk) disable iff (rst)
    grant |-> st == ST_DONE);
  // R2
  issue_into_idle_chk: assert property (@(posedge clk) disable iff (rst)
    iss_go |-> st == ST_IDLE);
endmodule

// File: rtl/sb_wr_arb.sv
module sb_wr_arb
  import sb_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM_FU-1:0] want,
  input  logic [REG_W-1:0] fi [NUM_FU],
  input  logic [REG_W-1:0] fj [NUM_FU],
  input  logic [REG_W-1:0] fk [NUM_FU],
  input  logic [NUM_FU-1:0] rj,
  input  logic [NUM_FU-1:0] rk,
  output logic [NUM_FU-1:0] grant
);
  logic [NUM_FU-1:0] blocked;
  logic [NUM_FU-1:0] elig;

  always_comb begin
    for (int f = 0; f < NUM_FU; f++) begin
      blocked[f] = 1'b0;
      for (int g = 0; g < NUM_FU; g++) begin
        if (g != f && war_pending(fj[g] == fi[f], rj[g], fk[g] == fi[f], rk[g]))
          blocked[f] = 1'b1;
      end
    end
  end

  assign elig  = want & ~blocked;
  assign grant = first_set(elig);

  // R9
  one_writer_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  // R9
  grant_needs_want_chk: assert property (@(posedge clk) disable iff (rst)
    (grant & ~want) == '0);
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int OP_W     = 4,
  parameter int LAT_INT  = 1,
  parameter int LAT_MUL  = 10,
  parameter int LAT_ADD  = 2,
  parameter int LAT_DIV  = 40,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [TAG_W-1:0]        in_fu,
  input  logic [OP_W-1:0]         in_op,
  input  logic [REG_W-1:0]        in_dst,
  input  logic [REG_W-1:0]        in_src1,
  input  logic [REG_W-1:0]        in_src2,
  output logic [NUM_FU-1:0]       rd_en,
  output logic [NUM_FU*REG_W-1:0] rd_addr1,
  output logic [NUM_FU*REG_W-1:0] rd_addr2,
  output logic [NUM_FU*OP_W-1:0]  start_op,
  output logic [NUM_FU-1:0]       ex_done,
  output logic                    wr_en,
  output logic [REG_W-1:0]        wr_addr,
  output logic [TAG_W-1:0]        wr_fu,
  output logic [NUM_FU-1:0]       fu_busy
);
  localparam int MAX_AM  = (LAT_INT > LAT_MUL) ? LAT_INT : LAT_MUL;
  localparam int MAX_AD  = (LAT_ADD > LAT_DIV) ? LAT_ADD : LAT_DIV;
  localparam int MAX_LAT = (MAX_AM > MAX_AD) ? MAX_AM : MAX_AD;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  fu_tag_t           tag_s1, tag_s2, tag_dst;
  logic [NUM_FU-1:0] sel_fu;
  logic              issue_fire;
  logic [NUM_FU-1:0] want, grant, s_rj, s_rk;
  logic [REG_W-1:0]  s_fi [NUM_FU];
  logic [REG_W-1:0]  s_fj [NUM_FU];
  logic [REG_W-1:0]  s_fk [NUM_FU];

  always_comb begin
    for (int i = 0; i < NUM_FU; i++) sel_fu[i] = (in_fu == TAG_W'(i + 1));
  end

  assign in_ready   = (|sel_fu) && ((sel_fu & fu_busy) == '0) && (tag_dst == '0);
  assign issue_fire = in_valid && in_ready;

  sb_regstat #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_regstat (
    .clk      (clk),
    .rst      (rst),
    .look_a   (in_src1),
    .look_b   (in_src2),
    .look_d   (in_dst),
    .tag_a    (tag_s1),
    .tag_b    (tag_s2),
    .tag_d    (tag_dst),
    .set_en   (issue_fire),
    .set_addr (in_dst),
    .set_tag  (in_fu),
    .clr_en   (wr_en),
    .clr_addr (wr_addr)
  );

  for (genvar i = 0; i < NUM_FU; i++) begin : g_slot
    localparam int SLOT_LAT = (i == 0) ? LAT_INT :
                              (i == 1) ? LAT_MUL :
                              (i == 2) ? LAT_ADD : LAT_DIV;
    logic [OP_W-1:0] slot_op;

    sb_fu_slot #(.REG_W(REG_W), .OP_W(OP_W), .CNT_W(CNT_W), .LAT(SLOT_LAT)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .iss_go  (issue_fire && sel_fu[i]),
      .iss_op  (in_op),
      .iss_fi  (in_dst),
      .iss_fj  (in_src1),
      .iss_fk  (in_src2),
      .iss_qj  (tag_s1),
      .iss_qk  (tag_s2),
      .wb_en   (wr_en),
      .wb_tag  (wr_fu),
      .grant   (grant[i]),
      .busy    (fu_busy[i]),
      .op      (slot_op),
      .fi      (s_fi[i]),
      .fj      (s_fj[i]),
      .fk      (s_fk[i]),
      .rj      (s_rj[i]),
      .rk      (s_rk[i]),
      .rd_go   (rd_en[i]),
      .done    (ex_done[i]),
      .want_wr (want[i])
    );

    assign rd_addr1[i*REG_W +: REG_W] = s_fj[i];
    assign rd_addr2[i*REG_W +: REG_W] = s_fk[i];
    assign start_op[i*OP_W +: OP_W]   = slot_op;
  end

  sb_wr_arb #(.REG_W(REG_W)) u_arb (
    .clk   (clk),
    .rst   (rst),
    .want  (want),
    .fi    (s_fi),
    .fj    (s_fj),
    .fk    (s_fk),
    .rj    (s_rj),
    .rk    (s_rk),
    .grant (grant)
  );

  always_comb begin
    wr_en   = |grant;
    wr_addr = '0;
    wr_fu   = '0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (grant[i]) begin
        wr_addr = wr_addr | s_fi[i];
        wr_fu   = wr_fu | TAG_W'(i + 1);
      end
    end
  end

  // observer built from the write port outputs, for the WAR check
  logic war_seen;
  always_comb begin
    war_seen = 1'b0;
    for (int g = 0; g < NUM_FU; g++) begin
      if (wr_fu != TAG_W'(g + 1) &&
          ((s_fj[g] == wr_addr && s_rj[g]) || (s_fk[g] == wr_addr && s_rk[g])))
        war_seen = 1'b1;
    end
  end

  // R8
  no_war_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !war_seen);
  // R2
  busy_count_chk: assert property (@(posedge clk) disable iff (rst)
    issue_fire |=> $countones(fu_busy) ==
                   $past($countones(fu_busy)) + 1 - ($past(wr_en) ? 1 : 0));
  // R10
  write_frees_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !issue_fire) |=> $countones(fu_busy) == $past($countones(fu_busy)) - 1);
endmodule

// File: tb/sb_ctrl_bench.sv
module sb_ctrl_bench;
  localparam int REG_W = 5;
  localparam int NFU   = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [2:0]       in_fu = '0;
  logic [3:0]       in_op = '0;
  logic [REG_W-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [NFU-1:0]   rd_en, ex_done, fu_busy;
  logic [NFU*REG_W-1:0] rd_addr1, rd_addr2;
  logic [NFU*4-1:0] start_op;
  logic             wr_en;
  logic [REG_W-1:0] wr_addr;
  logic [2:0]       wr_fu;

  sb_ctrl u_sb_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_fu(in_fu), .in_op(in_op), .in_dst(in_dst), .in_src1(in_src1),
    .in_src2(in_src2), .rd_en(rd_en), .rd_addr1(rd_addr1), .rd_addr2(rd_addr2),
    .start_op(start_op), .ex_done(ex_done), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_fu(wr_fu), .fu_busy(fu_busy)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0;
  int nfail = 0;
  int wr_cyc [1:4];
  int wr_reg [1:4];
  int rd_cyc [1:4];

  // records events mid low phase, once outputs have settled
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (wr_en) begin
        wr_cyc[int'(wr_fu)] = cyc;
        wr_reg[int'(wr_fu)] = int'(wr_addr);
      end
      for (int u = 0; u < NFU; u++) if (rd_en[u]) rd_cyc[u+1] = cyc;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int fu, input int d, input int s1, input int s2, output int at);
    @(negedge clk);
    in_valid = 1'b1;
    in_fu    = 3'(fu);
    in_op    = 4'(fu + 8);
    in_dst   = 5'(d);
    in_src1  = 5'(s1);
    in_src2  = 5'(s2);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    at = cyc;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain();
    do begin
      @(negedge clk);
      in_valid = 1'b0;
      #1;
    end while (fu_busy != '0);
    idle(1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    in_valid = 1'b1; in_fu = 3'd4; in_dst = 5'd0; in_src1 = 5'd1; in_src2 = 5'd2;
    #1;
    chk("R1 ready after reset", int'(in_ready), 1);
    chk("R1 busy after reset", int'(fu_busy), 0);
    chk("R1 no write after reset", int'(wr_en), 0);
    chk("R1 no read after reset", int'(rd_en), 0);
    in_valid = 1'b0;
  endtask

  task automatic t_independent();
    int a1, a2, a3, a4;
    push(1, 1, 20, 21, a1);
    push(2, 2, 22, 23, a2);
    push(3, 3, 24, 25, a3);
    push(4, 4, 26, 27, a4);
    idle(1);
    drain();
    chk("R5 int read", rd_cyc[1] - a1, 1);
    chk("R5 div read", rd_cyc[4] - a4, 1);
    chk("R7 int latency", wr_cyc[1] - a1, 3);
    chk("R7 mul latency", wr_cyc[2] - a2, 12);
    chk("R7 add latency", wr_cyc[3] - a3, 4);
    chk("R7 div latency", wr_cyc[4] - a4, 42);
    chk("R7 add completes before mul", int'(wr_cyc[3] < wr_cyc[2]), 1);
    chk("R10 mul write address", wr_reg[2], 2);
    chk("R10 div write address", wr_reg[4], 4);
  endtask

  task automatic t_structural();
    int a1, a2;
    push(3, 5, 20, 21, a1);
    push(3, 6, 22, 23, a2);
    idle(1);
    drain();
    chk("R2 busy adder holds request", a2 - a1, 5);
    chk("R7 second add latency", wr_cyc[3] - a2, 4);
  endtask

  task automatic t_waw();
    int a1, a2;
    push(2, 7, 20, 21, a1);
    push(3, 7, 22, 23, a2);
    idle(1);
    drain();
    chk("R3 WAW holds issue", a2 - a1, 13);
    chk("R3 add write after release", wr_cyc[3] - a2, 4);
    chk("R10 add write address", wr_reg[3], 7);
  endtask

  task automatic t_raw();
    int a1, a2, b1, b2;
    push(1, 8, 20, 21, a1);
    push(2, 9, 8, 8, a2);
    idle(1);
    drain();
    chk("R6 read after producer write", rd_cyc[2] - wr_cyc[1], 1);
    chk("R6 read cycle", rd_cyc[2] - a1, 4);
    chk("R7 mul after raw", wr_cyc[2] - a1, 15);
    push(1, 10, 20, 21, b1);
    idle(2);
    push(3, 11, 10, 22, b2);
    idle(1);
    drain();
    chk("R6 issue in producer write cycle", b2 - b1, 3);
    chk("R6 read one cycle after write", rd_cyc[3] - b1, 4);
    chk("R7 add after raw", wr_cyc[3] - b1, 7);
  endtask

  task automatic t_war();
    int a1, a2, a3;
    push(2, 12, 20, 21, a1);
    push(3, 13, 12, 14, a2);
    push(1, 14, 22, 23, a3);
    idle(1);
    drain();
    chk("R8 mul write", wr_cyc[2] - a1, 12);
    chk("R8 reader reads", rd_cyc[3] - a1, 13);
    chk("R8 WAR delayed write", wr_cyc[1] - a1, 14);
    chk("R8 reader write", wr_cyc[3] - a1, 16);
    chk("R10 int write address", wr_reg[1], 14);
  endtask

  task automatic t_arb();
    int a1, a2;
    push(3, 15, 20, 21, a1);
    push(1, 16, 22, 23, a2);
    idle(1);
    drain();
    chk("R9 lower code wins", wr_cyc[1] - a1, 4);
    chk("R9 loser retries", wr_cyc[3] - a1, 5);
  endtask

  task automatic t_badcode();
    int a1;
    @(negedge clk);
    in_valid = 1'b1; in_fu = 3'd0; in_dst = 5'd17; in_src1 = 5'd1; in_src2 = 5'd2;
    #1; chk("R4 code 0 refused", int'(in_ready), 0);
    @(negedge clk);
    in_fu = 3'd5;
    #1; chk("R4 code 5 refused", int'(in_ready), 0);
    @(negedge clk);
    in_fu = 3'd7;
    #1; chk("R4 code 7 refused", int'(in_ready), 0);
    @(negedge clk);
    in_valid = 1'b0;
    #1; chk("R4 units stay idle", int'(fu_busy), 0);
    push(4, 17, 1, 2, a1);
    idle(1);
    chk("R4 legal code then accepted", int'(fu_busy), 8);
    drain();
  endtask

  initial begin
    for (int u = 1; u <= 4; u++) begin
      wr_cyc[u] = -1; wr_reg[u] = -1; rd_cyc[u] = -1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_independent();
    t_structural();
    t_waw();
    t_raw();
    t_war();
    t_arb();
    t_badcode();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog all requirements actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule